// File: doc/BRIEF.md
# Extended Hamming (8,4) SEC-DED Codec

This block pairs an encoder and a decoder for a single-error-correcting, double-error-detecting code over a 4-bit nibble. The encoder maps a nibble to an 8-bit codeword. The data nibble sits in the upper half of the codeword and four check bits fill the lower half. A serial transmitter can ship that codeword inside its frame. The encoder path is purely combinational.

The decoder takes the 9-bit word assembled by a serial receiver. The top bit of that word is a constant filler that is always 1, and the decoder discards it. From the remaining eight bits the decoder recomputes the check bits and forms a 4-bit syndrome. From the syndrome it decides between three cases:
- the word is clean;
- one bit flipped and the data can be repaired;
- two bits flipped and the data is thrown away.

The decoder returns an 8-bit word for the host. The repaired nibble is in its low half and its high half is zero. Three mutually exclusive flags come with it. A parameter selects a registered decoder output, which is the default, or a combinational one.

Top module: `secded_codec`

## Requirements
- R1: The codeword is {d3,d2,d1,d0,c3,c2,c1,c0}: data nibble in bits 7:4, check bits in 3:0. The check bits are c0=d0^d1^d2, c1=d0^d1^d3, c2=d0^d2^d3 and c3=d1^d2^d3, so every codeword has an even number of ones.
- R2: Encoding the nibble 4'b0001 gives the codeword 8'b0001_0111 (0x17).
- R3: Bit 8 of the receive word has no effect on any decoder output.
- R4: A receive word whose low eight bits form a valid codeword raises only the clean flag, and the output carries that codeword's data nibble.
- R5: Flipping any single bit of bits 7:0 of a valid codeword raises only the corrected flag, and the output carries the original data nibble.
- R6: Flipping any two distinct bits of bits 7:0 of a valid codeword raises only the double-error flag, and the output data is zero.
- R7: Exactly one of the clean, corrected and double-error flags is high at all times.
- R8: Bits 7:4 of the decoded output are always zero.
- R9: With OUT_REG=1, the decoder outputs update on the rising clock edge after the receive word is applied. While rst_ni is low they hold data zero with only the clean flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional decoder output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 4 | Nibble to encode |
| enc_code_o | output | 8 | Encoded codeword, combinational |
| dec_word_i | input | 9 | Assembled receive word; bit 8 is filler |
| dec_data_o | output | 8 | Decoded data, nibble in bits 3:0 |
| dec_clean_o | output | 1 | No error found |
| dec_fixed_o | output | 1 | Single error corrected |
| dec_double_o | output | 1 | Double error detected, data discarded |

## Verification
The bench covers every nibble with the clean word, all eight single flips and all 28 double flips. The single flips include flips that land only on check bits. A decoder that "repairs" data on a check-bit error would corrupt the nibble. One that mistakes a weight-2 syndrome for a data column would return a wrong nibble under the corrected flag instead of raising the double flag. Further directed cases clear the filler bit to catch a decoder that folds it into the syndrome. They also hold the inputs busy during reset and sample just before and just after the clock edge, to expose a wrong reset value or a missing or extra output stage.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned CODE_W = DATA_W + CHK_W;
  localparam int unsigned RX_W   = CODE_W + 1;
  localparam int unsigned OUT_W  = 8;

  typedef logic [DATA_W-1:0] nib_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic clean;
    logic fixed;
    logic dbl;
  } flags_t;

  localparam flags_t FLAGS_CLEAN = '{clean: 1'b1, fixed: 1'b0, dbl: 1'b0};

  function automatic chk_t calc_chk(nib_t d);
    chk_t c;
    c[0] = d[0] ^ d[1] ^ d[2];
    c[1] = d[0] ^ d[1] ^ d[3];
    c[2] = d[0] ^ d[2] ^ d[3];
    c[3] = d[1] ^ d[2] ^ d[3];
    return c;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  nib_t  data_i,
  output code_t code_o
);
  assign code_o = {data_i, calc_chk(data_i)};
endmodule

// File: rtl/secded_syn.sv
module secded_syn
  import secded_pkg::*;
(
  input  code_t code_i,
  output chk_t  syn_o
);
  assign syn_o = calc_chk(code_i[CODE_W-1:CHK_W]) ^ code_i[CHK_W-1:0];
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
(
  input  code_t  code_i,
  input  chk_t   syn_i,
  output nib_t   data_o,
  output flags_t flags_o
);
  localparam int unsigned WT_W = $clog2(CHK_W + 1);

  nib_t            flip;
  logic [WT_W-1:0] wt;
  nib_t            raw;

  assign raw = code_i[CODE_W-1:CHK_W];
  assign wt  = WT_W'($countones(syn_i));

  // a data bit is flipped when the syndrome equals its check column
  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    assign flip[i] = (syn_i == calc_chk(nib_t'(1 << i)));
  end

  always_comb begin
    flags_o = '0;
    data_o  = '0;
    if (syn_i == '0) begin
      flags_o.clean = 1'b1;
      data_o        = raw;
    end else if (wt[0]) begin
      // odd weight: single error, check-bit hits leave flip at zero
      flags_o.fixed = 1'b1;
      data_o        = raw ^ flip;
    end else begin
      flags_o.dbl = 1'b1;
    end
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic [RX_W-1:0]   dec_word_i,
  output logic [OUT_W-1:0]  dec_data_o,
  output logic              dec_clean_o,
  output logic              dec_fixed_o,
  output logic              dec_double_o
);
  code_t  rx_code;
  chk_t   syn;
  nib_t   fix_data;
  flags_t fix_flags;
  nib_t   out_data;
  flags_t out_flags;
  logic   unused_filler;

  assign rx_code       = dec_word_i[CODE_W-1:0];
  assign unused_filler = dec_word_i[RX_W-1];

  secded_enc i_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  secded_syn i_syn (
    .code_i (rx_code),
    .syn_o  (syn)
  );

  secded_fix i_fix (
    .code_i  (rx_code),
    .syn_i   (syn),
    .data_o  (fix_data),
    .flags_o (fix_flags)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_data  <= '0;
        out_flags <= FLAGS_CLEAN;
      end else begin
        out_data  <= fix_data;
        out_flags <= fix_flags;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign out_data   = fix_data;
    assign out_flags  = fix_flags;
  end

  assign dec_data_o   = {{(OUT_W-DATA_W){1'b0}}, out_data};
  assign dec_clean_o  = out_flags.clean;
  assign dec_fixed_o  = out_flags.fixed;
  assign dec_double_o = out_flags.dbl;
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] enc_data_i,
  input logic [CODE_W-1:0] enc_code_o,
  input logic [RX_W-1:0]   dec_word_i,
  input logic [OUT_W-1:0]  dec_data_o,
  input logic              dec_clean_o,
  input logic              dec_fixed_o,
  input logic              dec_double_o
);
  p_code_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(enc_code_o) % 2 == 0);

  p_one_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({dec_clean_o, dec_fixed_o, dec_double_o}) == 1);

  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_data_o[OUT_W-1:DATA_W] == '0);

  p_double_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_double_o |-> dec_data_o == '0);

  if (OUT_REG) begin : g_rt_reg
    p_roundtrip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_word_i[CODE_W-1:0] == enc_code_o)
      |=> (dec_clean_o && dec_data_o[DATA_W-1:0] == $past(enc_data_i)));
  end else begin : g_rt_comb
    p_roundtrip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_word_i[CODE_W-1:0] == enc_code_o)
      |-> (dec_clean_o && dec_data_o[DATA_W-1:0] == enc_data_i));
  end
endmodule

bind secded_codec secded_codec_chk #(.OUT_REG(OUT_REG)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enc_data_i   (enc_data_i),
  .enc_code_o   (enc_code_o),
  .dec_word_i   (dec_word_i),
  .dec_data_o   (dec_data_o),
  .dec_clean_o  (dec_clean_o),
  .dec_fixed_o  (dec_fixed_o),
  .dec_double_o (dec_double_o)
);

// File: tb/test_secded_codec.sv
module test_secded_codec;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic [7:0] enc_code_o;
  logic [8:0] dec_word_i = 9'h003;
  logic [7:0] dec_data_o;
  logic       dec_clean_o, dec_fixed_o, dec_double_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected codewords, hand-derived from the R1 equations
  localparam logic [7:0] ENC_TAB [16] = '{
    8'h00, 8'h17, 8'h2B, 8'h3C, 8'h4D, 8'h5A, 8'h66, 8'h71,
    8'h8E, 8'h99, 8'hA5, 8'hB2, 8'hC3, 8'hD4, 8'hE8, 8'hFF};

  always #2 clk_i = ~clk_i;

  secded_codec i_secded_codec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enc_data_i   (enc_data_i),
    .enc_code_o   (enc_code_o),
    .dec_word_i   (dec_word_i),
    .dec_data_o   (dec_data_o),
    .dec_clean_o  (dec_clean_o),
    .dec_fixed_o  (dec_fixed_o),
    .dec_double_o (dec_double_o)
  );

  task automatic chk_out(string req, logic [7:0] ed, logic [2:0] ef);
    checks++;
    if (dec_data_o !== ed || {dec_clean_o, dec_fixed_o, dec_double_o} !== ef) begin
      failures++;
      $display("FAIL %s actual data=%h flags=%b expected data=%h flags=%b",
               req, dec_data_o, {dec_clean_o, dec_fixed_o, dec_double_o}, ed, ef);
    end
  endtask

  task automatic dec_apply(logic [8:0] w);
    @(negedge clk_i);
    dec_word_i = w;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    // R9: reset state while a double-error word is on the input
    #9;
    chk_out("R9 reset", 8'h00, 3'b100);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk_out("R6 after reset", 8'h00, 3'b001);

    // table walk: encode, clean decode, every single and double flip
    for (int d = 0; d < 16; d++) begin
      @(negedge clk_i);
      enc_data_i = 4'(d);
      #1;
      checks++;
      if (enc_code_o !== ENC_TAB[d]) begin
        failures++;
        $display("FAIL R1 actual=%h expected=%h", enc_code_o, ENC_TAB[d]);
      end
      dec_apply({1'b1, ENC_TAB[d]});
      chk_out("R4 clean", {4'h0, 4'(d)}, 3'b100);
      for (int i = 0; i < 8; i++) begin
        dec_apply({1'b1, ENC_TAB[d] ^ 8'(1 << i)});
        chk_out("R5 single", {4'h0, 4'(d)}, 3'b010);
        for (int j = i + 1; j < 8; j++) begin
          dec_apply({1'b1, ENC_TAB[d] ^ 8'(1 << i) ^ 8'(1 << j)});
          chk_out("R6 double", 8'h00, 3'b001);
        end
      end
    end

    // R2: spec example
    @(negedge clk_i);
    enc_data_i = 4'b0001;
    #1;
    checks++;
    if (enc_code_o !== 8'b0001_0111) begin
      failures++;
      $display("FAIL R2 actual=%b expected=00010111", enc_code_o);
    end

    // R3: filler bit cleared has no effect
    dec_apply({1'b0, ENC_TAB[9]});
    chk_out("R3 clean", 8'h09, 3'b100);
    dec_apply({1'b0, ENC_TAB[6] ^ 8'h40});
    chk_out("R3 single", 8'h06, 3'b010);
    dec_apply({1'b0, ENC_TAB[6] ^ 8'h81});
    chk_out("R3 double", 8'h00, 3'b001);

    // R9: one-cycle latency, output holds until the edge
    dec_apply({1'b1, ENC_TAB[5]});
    dec_word_i = {1'b1, ENC_TAB[10]};
    #1;
    chk_out("R9 before edge", 8'h05, 3'b100);
    @(posedge clk_i);
    #1;
    chk_out("R9 after edge", 8'h0A, 3'b100);

    // R8: high half stays zero for nibble 15 under a check-bit flip
    dec_apply({1'b1, ENC_TAB[15] ^ 8'h08});
    chk_out("R8 upper", 8'h0F, 3'b010);

    // R9: asynchronous reset mid-run
    #1;
    rst_ni = 1'b0;
    #1;
    chk_out("R9 async reset", 8'h00, 3'b100);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule